// File: doc/BRIEF.md
# Link Deframer with Sync Alignment

This block sits at the receive end of one front-end data link. Each clock it may take one fixed-width frame, qualified by a valid flag. A special synchronisation frame locks the block onto the stream and tells it which bunch-crossing identifier the next event carries. After a sync frame the block reads a header frame, takes the payload length from it, and passes that many payload frames on before it expects the next header. Events may therefore span any number of frames, with idle frames between them. Every recovered frame leaves on a streaming output tagged with start, end, crossing identifier and a truncation mark. The output is registered one cycle behind the input.

The block predicts the crossing identifier of each header. A wrong identifier, or a length the packing cannot hold, raises a sticky desynchronisation flag. A sync frame that arrives while an event is still open closes that event at once with a truncated end beat. The stream then restarts from the next header. A pass-through input turns off the crossing sequence check so every well-formed event is accepted.

Top module: `link_deframer`

## Requirements
- R1: After reset no output beat is valid, `locked` is 0 and `desync` is 0.
- R2: A valid frame whose bits [31:16] equal 0xBC5A and bits [15:12] equal 0 is a sync frame carrying the next crossing identifier in bits [11:0]. Before the first sync, every frame is dropped and `locked` stays 0. A sync sets `locked` to 1.
- R3: A header frame holds the crossing identifier in bits [11:0] and the payload length (count of payload frames that follow) in bits [23:16]. Each event leaves as 1+length beats one cycle after each input frame. The header beat has `ev_sop`=1 and carries the header frame as data. The last beat has `ev_eop`=1 (a length of 0 puts both on the header beat). Every beat carries the header's identifier on `ev_bxid`.
- R4: A frame with `in_valid` low is skipped whatever its content. It produces no beat and does not advance the event.
- R5: The first header after a sync must carry the identifier the sync gave. Each later header must carry the previous header's identifier plus one, wrapping from 3563 to 0. A mismatch sets `desync`, but the event is still output.
- R6: A sync frame arriving inside an event's payload emits one beat with data 0, `ev_eop`=1, `ev_trunc`=1 and the open event's identifier. A sync arriving between events emits nothing.
- R7: A header with length above 16 sets `desync`, emits nothing and returns the block to the unlocked state (`locked`=0) until the next sync.
- R8: `desync` is sticky. Only a sync frame or a cycle with `desync_clr` high clears it. An error in the same cycle as `desync_clr` leaves it set.
- R9: With `pass_thru` high, an identifier mismatch does not set `desync`. The length check of R7 still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame qualifier; low marks an idle frame |
| in_frame | input | 32 | Received link frame |
| pass_thru | input | 1 | Disable the crossing identifier sequence check |
| desync_clr | input | 1 | Clear the desynchronisation flag |
| ev_valid | output | 1 | Output beat valid |
| ev_data | output | 32 | Output beat data |
| ev_sop | output | 1 | First beat of an event (header) |
| ev_eop | output | 1 | Last beat of an event |
| ev_bxid | output | 12 | Crossing identifier of the event |
| ev_trunc | output | 1 | Event closed early by a sync frame |
| desync | output | 1 | Sticky desynchronisation flag |
| locked | output | 1 | Block is aligned and parsing headers |

## Verification
Assertions hold on every cycle for several properties. Idle input never yields a beat, and no beat follows a cycle spent unlocked. A truncation mark always travels with an end beat. The desynchronisation flag never drops without a sync or a clear, and a sync always leaves the block locked and clean. The correctness of the data itself can only be shown by the bench's scenarios against a queue of expected beats. Those scenarios cover the beat boundaries, the crossing tags, the predicted identifier including its wrap at the orbit end, the truncation beat's placement and identifier, and the pass-through and oversize-length cases.

// File: rtl/link_deframer_pkg.sv
package link_deframer_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_HDR  = 2'd1,
        ST_BODY = 2'd2
    } dfr_state_e;
endpackage

// File: rtl/dfr_sync_detect.sv
module dfr_sync_detect #(
    parameter int FRAME_W = 32,
    parameter int BX_W    = 12,
    parameter int MARK_W  = 16,
    parameter logic [MARK_W-1:0] SYNC_MARK = 16'hBC5A
) (
    input  logic [FRAME_W-1:0] frame,
    output logic               is_sync,
    output logic [BX_W-1:0]    sync_bx
);
    localparam int GAP_HI = FRAME_W - MARK_W - 1;

    logic mark_ok;
    logic gap_ok;

    always_comb begin
        mark_ok = (frame[FRAME_W-1 -: MARK_W] == SYNC_MARK);
        gap_ok  = (frame[GAP_HI:BX_W] == '0);
        is_sync = mark_ok && gap_ok;
        sync_bx = frame[BX_W-1:0];
    end
endmodule

// File: rtl/dfr_hdr_check.sv
module dfr_hdr_check #(
    parameter int BX_W    = 12,
    parameter int LEN_W   = 8,
    parameter int MAX_LEN = 16,
    parameter int ORBIT   = 3564
) (
    input  logic [BX_W-1:0]  hdr_bx,
    input  logic [LEN_W-1:0] hdr_len,
    input  logic [BX_W-1:0]  exp_bx,
    input  logic             pass_thru,
    output logic             len_ok,
    output logic             bx_err,
    output logic [BX_W-1:0]  next_bx
);
    localparam logic [BX_W-1:0]  LAST_BX = BX_W'(ORBIT - 1);
    localparam logic [LEN_W-1:0] LEN_LIM = LEN_W'(MAX_LEN);

    always_comb begin
        len_ok  = (hdr_len <= LEN_LIM);
        bx_err  = !pass_thru && (hdr_bx != exp_bx);
        next_bx = (hdr_bx >= LAST_BX) ? '0 : hdr_bx + 1'b1;
    end
endmodule

// File: rtl/link_deframer.sv
module link_deframer
    import link_deframer_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int BX_W    = 12,
    parameter int LEN_W   = 8,
    parameter int LEN_LSB = 16,
    parameter int MAX_LEN = 16,
    parameter int ORBIT   = 3564,
    parameter logic [15:0] SYNC_MARK = 16'hBC5A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [FRAME_W-1:0] in_frame,
    input  logic               pass_thru,
    input  logic               desync_clr,
    output logic               ev_valid,
    output logic [FRAME_W-1:0] ev_data,
    output logic               ev_sop,
    output logic               ev_eop,
    output logic [BX_W-1:0]    ev_bxid,
    output logic               ev_trunc,
    output logic               desync,
    output logic               locked
);
    localparam logic [LEN_W-1:0] ONE_LEFT = LEN_W'(1);

    typedef struct packed {
        dfr_state_e         st;
        logic [BX_W-1:0]    exp_bx;
        logic [BX_W-1:0]    cur_bx;
        logic [LEN_W-1:0]   remain;
        logic               desync;
        logic               o_valid;
        logic [FRAME_W-1:0] o_data;
        logic               o_sop;
        logic               o_eop;
        logic [BX_W-1:0]    o_bx;
        logic               o_trunc;
    } dfr_regs_t;

    dfr_regs_t r_d, r_q;

    logic            is_sync;
    logic [BX_W-1:0] sync_bx;
    logic            len_ok;
    logic            bx_err;
    logic [BX_W-1:0] next_bx;
    logic [BX_W-1:0] hdr_bx;
    logic [LEN_W-1:0] hdr_len;

    assign hdr_bx  = in_frame[BX_W-1:0];
    assign hdr_len = in_frame[LEN_LSB +: LEN_W];

    dfr_sync_detect #(
        .FRAME_W  (FRAME_W),
        .BX_W     (BX_W),
        .MARK_W   (16),
        .SYNC_MARK(SYNC_MARK)
    ) u_sync (
        .frame  (in_frame),
        .is_sync(is_sync),
        .sync_bx(sync_bx)
    );

    dfr_hdr_check #(
        .BX_W   (BX_W),
        .LEN_W  (LEN_W),
        .MAX_LEN(MAX_LEN),
        .ORBIT  (ORBIT)
    ) u_hdr (
        .hdr_bx   (hdr_bx),
        .hdr_len  (hdr_len),
        .exp_bx   (r_q.exp_bx),
        .pass_thru(pass_thru),
        .len_ok   (len_ok),
        .bx_err   (bx_err),
        .next_bx  (next_bx)
    );

    always_comb begin
        r_d         = r_q;
        r_d.o_valid = 1'b0;
        r_d.o_sop   = 1'b0;
        r_d.o_eop   = 1'b0;
        r_d.o_trunc = 1'b0;
        if (desync_clr) begin
            r_d.desync = 1'b0;
        end
        if (in_valid) begin
            if (is_sync) begin
                if (r_q.st == ST_BODY) begin
                    r_d.o_valid = 1'b1;
                    r_d.o_data  = '0;
                    r_d.o_eop   = 1'b1;
                    r_d.o_trunc = 1'b1;
                    r_d.o_bx    = r_q.cur_bx;
                end
                r_d.st     = ST_HDR;
                r_d.exp_bx = sync_bx;
                r_d.remain = '0;
                r_d.desync = 1'b0;
            end else begin
                case (r_q.st)
                    ST_HDR: begin
                        if (!len_ok) begin
                            r_d.desync = 1'b1;
                            r_d.st     = ST_HUNT;
                        end else begin
                            r_d.o_valid = 1'b1;
                            r_d.o_data  = in_frame;
                            r_d.o_sop   = 1'b1;
                            r_d.o_eop   = (hdr_len == '0);
                            r_d.o_bx    = hdr_bx;
                            r_d.cur_bx  = hdr_bx;
                            r_d.exp_bx  = next_bx;
                            if (bx_err) begin
                                r_d.desync = 1'b1;
                            end
                            if (hdr_len != '0) begin
                                r_d.remain = hdr_len;
                                r_d.st     = ST_BODY;
                            end
                        end
                    end
                    ST_BODY: begin
                        r_d.o_valid = 1'b1;
                        r_d.o_data  = in_frame;
                        r_d.o_eop   = (r_q.remain == ONE_LEFT);
                        r_d.o_bx    = r_q.cur_bx;
                        r_d.remain  = r_q.remain - 1'b1;
                        if (r_q.remain == ONE_LEFT) begin
                            r_d.st = ST_HDR;
                        end
                    end
                    default: begin
                        r_d.st = ST_HUNT;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ev_valid = r_q.o_valid;
    assign ev_data  = r_q.o_data;
    assign ev_sop   = r_q.o_sop;
    assign ev_eop   = r_q.o_eop;
    assign ev_bxid  = r_q.o_bx;
    assign ev_trunc = r_q.o_trunc;
    assign desync   = r_q.desync;
    assign locked   = (r_q.st != ST_HUNT);

    // R4: idle input never produces a beat
    a_r4_idle_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> !ev_valid);

    // R2: nothing leaves the block while it hunts for a sync
    a_r2_no_beat_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> $past(r_q.st) != ST_HUNT);

    // R6: a truncation mark closes an event
    a_r6_trunc_is_eop: assert property (@(posedge clk) disable iff (!rst_n)
        ev_trunc |-> (ev_valid && ev_eop && !ev_sop));

    // R8: the flag only drops through a sync or a clear
    a_r8_desync_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.desync) && !$past(desync_clr) && !$past(in_valid && is_sync))
        |-> desync);

    // R2: a sync frame relocks with a clean flag
    a_r2_sync_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && is_sync) |-> (locked && !desync));

    // R7: an oversize length drops the lock and emits nothing
    a_r7_len_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid && !is_sync && !len_ok) && $past(r_q.st) == ST_HDR)
        |-> (!locked && desync && !ev_valid));
endmodule

// File: tb/link_deframer_bench.sv
module link_deframer_bench;
    localparam logic [15:0] MARK = 16'hBC5A;

    typedef struct packed {
        logic [31:0] data;
        logic        sop;
        logic        eop;
        logic [11:0] bx;
        logic        trunc;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_frame = '0;
    logic        pass_thru = 1'b0;
    logic        desync_clr = 1'b0;
    logic        ev_valid;
    logic [31:0] ev_data;
    logic        ev_sop;
    logic        ev_eop;
    logic [11:0] ev_bxid;
    logic        ev_trunc;
    logic        desync;
    logic        locked;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    beat_t exp_q[$];

    always #5 clk = ~clk;

    link_deframer u_link_deframer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frame(in_frame),
        .pass_thru(pass_thru), .desync_clr(desync_clr),
        .ev_valid(ev_valid), .ev_data(ev_data), .ev_sop(ev_sop),
        .ev_eop(ev_eop), .ev_bxid(ev_bxid), .ev_trunc(ev_trunc),
        .desync(desync), .locked(locked)
    );

    function automatic logic [31:0] hdr(input int bx, input int len);
        return {8'h00, 8'(len), 4'h0, 12'(bx)};
    endfunction

    function automatic logic [31:0] syncf(input int bx);
        return {MARK, 4'h0, 12'(bx)};
    endfunction

    function automatic logic [31:0] pay(input int bx, input int i);
        return 32'h7700_0000 | (32'(bx) << 8) | 32'(i);
    endfunction

    task automatic push(input logic [31:0] d, input logic s, input logic e,
                        input int bx, input logic t);
        beat_t b;
        b.data = d; b.sop = s; b.eop = e; b.bx = 12'(bx); b.trunc = t;
        exp_q.push_back(b);
    endtask

    task automatic drive(input logic v, input logic [31:0] d);
        @(negedge clk);
        in_valid = v;
        in_frame = d;
    endtask

    // R4: idle frame carrying a sync-looking word must be ignored
    task automatic idle_junk();
        drive(1'b0, syncf(5));
    endtask

    task automatic send_sync(input int bx, input bit open_ev, input int open_bx);
        drive(1'b1, syncf(bx));
        if (open_ev) push(32'h0, 1'b0, 1'b1, open_bx, 1'b1);
    endtask

    task automatic send_event(input int bx, input int len, input int sent,
                              input bit gaps);
        drive(1'b1, hdr(bx, len));
        push(hdr(bx, len), 1'b1, (len == 0), bx, 1'b0);
        for (int i = 0; i < sent; i++) begin
            if (gaps) idle_junk();
            drive(1'b1, pay(bx, i));
            push(pay(bx, i), 1'b0, (i == len - 1), bx, 1'b0);
        end
    endtask

    task automatic check_flags(input string req, input logic exp_lock,
                               input logic exp_desync);
        @(negedge clk);
        in_valid = 1'b0;
        desync_clr = 1'b0;
        #1;
        checks++;
        if (locked !== exp_lock || desync !== exp_desync) begin
            fails++;
            $display("FAIL %s: locked=%0b desync=%0b expected locked=%0b desync=%0b",
                     req, locked, desync, exp_lock, exp_desync);
        end
    endtask

    task automatic clear_pulse();
        @(negedge clk);
        in_valid = 1'b0;
        desync_clr = 1'b1;
    endtask

    // Monitor: every output beat is compared against the queue head
    always @(negedge clk) begin
        if (rst_n && ev_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R3: unexpected beat data=%h bx=%0d expected no beat",
                         ev_data, ev_bxid);
            end else begin
                beat_t e;
                e = exp_q.pop_front();
                if (ev_data !== e.data || ev_sop !== e.sop || ev_eop !== e.eop ||
                    ev_bxid !== e.bx || ev_trunc !== e.trunc) begin
                    fails++;
                    $display("FAIL R3/R6: beat d=%h s=%0b e=%0b bx=%0d t=%0b expected d=%h s=%0b e=%0b bx=%0d t=%0b",
                             ev_data, ev_sop, ev_eop, ev_bxid, ev_trunc,
                             e.data, e.sop, e.eop, e.bx, e.trunc);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (ev_valid !== 1'b0 || locked !== 1'b0 || desync !== 1'b0) begin
            fails++;
            $display("FAIL R1: valid=%0b locked=%0b desync=%0b expected 0 0 0",
                     ev_valid, locked, desync);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: frames before the first sync are dropped
        drive(1'b1, hdr(7, 0));
        drive(1'b1, pay(7, 0));
        check_flags("R2 unlocked", 1'b0, 1'b0);

        // R2/R3/R4: lock, events with gaps and header-only
        send_sync(100, 1'b0, 0);
        check_flags("R2 lock", 1'b1, 1'b0);
        send_event(100, 2, 2, 1'b1);
        send_event(101, 0, 0, 1'b0);
        send_event(102, 3, 3, 1'b0);
        check_flags("R5 in sequence", 1'b1, 1'b0);

        // R5/R8: mismatch flags, stays sticky, clear drops it
        send_event(110, 1, 1, 1'b0);
        send_event(111, 0, 0, 1'b0);
        check_flags("R8 sticky", 1'b1, 1'b1);
        clear_pulse();
        check_flags("R8 clear", 1'b1, 1'b0);
        send_event(112, 0, 0, 1'b0);
        check_flags("R5 follows received", 1'b1, 1'b0);

        // R8: error in the clear cycle keeps the flag
        desync_clr = 1'b1;
        send_event(200, 0, 0, 1'b0);
        check_flags("R8 set wins", 1'b1, 1'b1);

        // R6: sync mid-payload truncates; sync clears desync
        send_event(201, 3, 1, 1'b0);
        send_sync(3562, 1'b1, 201);
        check_flags("R6 sync clears", 1'b1, 1'b0);

        // R5: wrap at orbit end
        send_event(3562, 1, 1, 1'b0);
        send_event(3563, 0, 0, 1'b0);
        send_event(0, 2, 2, 1'b1);
        check_flags("R5 wrap", 1'b1, 1'b0);

        // R6: sync between events emits nothing
        send_sync(40, 1'b0, 0);
        send_event(40, 0, 0, 1'b0);
        check_flags("R6 no open event", 1'b1, 1'b0);

        // R7: oversize length unlocks, later frames dropped
        drive(1'b1, hdr(41, 17));
        drive(1'b1, pay(41, 0));
        drive(1'b1, hdr(42, 0));
        check_flags("R7 oversize", 1'b0, 1'b1);
        send_sync(9, 1'b0, 0);
        send_event(9, 16, 16, 1'b0);
        check_flags("R7 max length ok", 1'b1, 1'b0);

        // R9: pass-through ignores sequence, still checks length
        pass_thru = 1'b1;
        send_event(500, 1, 1, 1'b0);
        send_event(77, 0, 0, 1'b0);
        check_flags("R9 no bx check", 1'b1, 1'b0);
        drive(1'b1, hdr(78, 20));
        check_flags("R9 length still checked", 1'b0, 1'b1);
        pass_thru = 1'b0;

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R3: %0d beats missing expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule